// File: doc/BRIEF.md
# Bus Fault Exception Sequencer

This block sits in the control path of a 32-bit processor core. It decides how exception entry begins after a memory access fails. A failed access is either a bus error reported by the bus interface or an instruction fetch aimed at an odd byte address, which the prefetch unit flags. An odd fetch never reaches the bus. The block raises an inhibit for that fetch in the same cycle and starts exception entry on the next clock edge.

When a fault is accepted, the block latches a one-cycle start pulse and the exception vector, both as a number and as a byte offset. It also latches a format code that tells the stack writer whether a short or a long fault frame is needed, together with the program counter of the instruction that was running. It keeps an untouched copy of the status register and forms the new status word, which has the supervisor bit set and both trace bits cleared.

Exception processing counts as in progress from reset, and again from each accepted fault, until the core reports that the new program counter has been read from the vector. A further fault in that window, or a fault while a return-from-exception instruction is reloading state from the stack, is a double fault. On a double fault the block halts. It keeps its status pin asserted and withdraws its memory-write enable, and it stays halted until the external reset.

Top module: `fault_entry_seq`

## Requirements
- R1: When a fault is accepted, `sr_saved_o` holds the status word from the fault cycle. `sr_new_o` holds the same word with bit 13 (supervisor) set, bits 15 and 14 (trace) cleared, and every other bit unchanged.
- R2: An accepted bus error gives vector number 2 and vector offset 8, the offset being always the vector number times four.
- R3: An accepted odd-address fetch gives vector number 3 and vector offset 12. `fetch_inhibit_o` follows `odd_fetch_i` in the same cycle.
- R4: When a bus error and an odd fetch arrive in the same cycle, the bus error wins and vector 2 is used.
- R5: A fault taken with `boundary_i` high selects the short frame: `long_frame_o` is 0 and the format code is 4'hA. A fault taken with `boundary_i` low selects the long frame: `long_frame_o` is 1 and the format code is 4'hB.
- R6: `pc_saved_o` holds the `pc_i` value present in the cycle the fault was accepted.
- R7: A fault that arrives after an accepted fault and before `vec_fetched_i` is a double fault. `halted_o` rises on the next edge and no start pulse is issued.
- R8: A fault while `rte_restore_i` is high is a double fault and halts the block. `rte_restore_i` alone does not halt it.
- R9: After reset, exception processing is in progress until `vec_fetched_i` is seen. A fault before that halts the block.
- R10: While halted, `status_o` is 1 and `mem_wr_en_o` is 0, and faults produce no start pulse. Only reset clears the halt.
- R11: After `vec_fetched_i`, a single fault is accepted normally.
- R12: `take_o` is a one-cycle pulse on the edge after the fault cycle. The latched outputs hold their values until the next accepted fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | External reset, active low, asynchronous |
| bus_err_i | input | 1 | Bus interface reports a failed access |
| odd_fetch_i | input | 1 | Prefetch unit targets an odd address |
| boundary_i | input | 1 | Fault falls on an instruction boundary |
| rte_restore_i | input | 1 | Return-from-exception is reloading state |
| vec_fetched_i | input | 1 | New program counter read from the vector |
| sr_i | input | 16 | Current status register |
| pc_i | input | 32 | Address of the executing instruction |
| fetch_inhibit_o | output | 1 | Suppress the bus cycle for this fetch |
| take_o | output | 1 | Exception entry start pulse |
| vec_num_o | output | 8 | Exception vector number |
| vec_off_o | output | 10 | Vector byte offset for the frame |
| frame_fmt_o | output | 4 | Frame format code |
| long_frame_o | output | 1 | 1 selects the long fault frame |
| sr_saved_o | output | 16 | Internal copy of the status register |
| sr_new_o | output | 16 | Status word to install |
| pc_saved_o | output | 32 | Program counter to stack |
| halted_o | output | 1 | Double-fault halt state |
| status_o | output | 1 | Status pin, held high while halted |
| mem_wr_en_o | output | 1 | Memory writes permitted |

## Verification
The assertions assume that the fault inputs are synchronous pulses sampled on the rising edge. They also assume that `vec_fetched_i` is raised only while exception entry is actually in progress. The bench drives every input on the falling edge and raises `vec_fetched_i` only between faults, never in a fault cycle. It samples the registered outputs just after the rising edge. The bench raises both fault inputs together only in the vectors that check the bus-error priority.

// File: rtl/fe_pkg.sv
package fe_pkg;
   typedef enum logic [1:0] {
      FK_NONE = 2'd0,
      FK_BUS  = 2'd1,
      FK_ADDR = 2'd2
   } fault_kind_e;
endpackage

// File: rtl/fe_classify.sv
module fe_classify
   import fe_pkg::*;
#(
   parameter int             VEC_W      = 8,
   parameter int             SR_W       = 16,
   parameter int             SUP_BIT    = 13,
   parameter logic [15:0]    TRACE_MASK = 16'hC000,
   parameter int             FMT_W      = 4,
   parameter logic [3:0]     FMT_SHORT  = 4'hA,
   parameter logic [3:0]     FMT_LONG   = 4'hB,
   parameter int             VEC_BUS    = 2,
   parameter int             VEC_ADDR   = 3,
   parameter bit             BUS_WINS   = 1'b1
) (
   input  logic              bus_err_i,
   input  logic              odd_fetch_i,
   input  logic              boundary_i,
   input  logic [SR_W-1:0]   sr_i,
   output logic              fault_o,
   output logic [VEC_W-1:0]  vec_o,
   output logic [VEC_W+1:0]  off_o,
   output logic [FMT_W-1:0]  fmt_o,
   output logic              long_o,
   output logic [SR_W-1:0]   sr_new_o
);
   localparam logic [SR_W-1:0] SUP_MASK = SR_W'(1) << SUP_BIT;
   localparam logic [SR_W-1:0] TRC_MASK = SR_W'(TRACE_MASK);

   generate
      if (SUP_BIT >= SR_W) begin : g_bad_sup
         $error("SUP_BIT outside status register");
      end
      if ((TRACE_MASK & 16'(SUP_MASK)) != 16'h0) begin : g_bad_trace
         $error("trace mask overlaps supervisor bit");
      end
      if (VEC_BUS == VEC_ADDR) begin : g_bad_vec
         $error("bus and address vectors must differ");
      end
      if (FMT_SHORT == FMT_LONG) begin : g_bad_fmt
         $error("frame format codes must differ");
      end
   endgenerate

   fault_kind_e kind;

   generate
      if (BUS_WINS) begin : g_bus_first
         always_comb begin
            if (bus_err_i)        kind = FK_BUS;
            else if (odd_fetch_i) kind = FK_ADDR;
            else                  kind = FK_NONE;
         end
      end else begin : g_addr_first
         always_comb begin
            if (odd_fetch_i)      kind = FK_ADDR;
            else if (bus_err_i)   kind = FK_BUS;
            else                  kind = FK_NONE;
         end
      end
   endgenerate

   always_comb begin
      fault_o = (kind != FK_NONE);
      vec_o   = (kind == FK_ADDR) ? VEC_W'(VEC_ADDR) : VEC_W'(VEC_BUS);
      off_o   = {vec_o, 2'b00};
      long_o  = ~boundary_i;
      fmt_o   = boundary_i ? FMT_W'(FMT_SHORT) : FMT_W'(FMT_LONG);
      sr_new_o = (sr_i | SUP_MASK) & ~TRC_MASK;
   end
endmodule

// File: rtl/fe_halt_track.sv
module fe_halt_track #(
   parameter bit RESET_IN_EXC = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fault_i,
   input  logic rte_restore_i,
   input  logic vec_fetched_i,
   output logic accept_o,
   output logic halted_o
);
   logic in_exc_q;
   logic halted_q;
   logic dbl;

   always_comb begin
      dbl      = fault_i & (in_exc_q | rte_restore_i) & ~halted_q;
      accept_o = fault_i & ~in_exc_q & ~rte_restore_i & ~halted_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halted_q <= 1'b0;
         in_exc_q <= RESET_IN_EXC;
      end else begin
         if (dbl) halted_q <= 1'b1;
         if (accept_o)           in_exc_q <= 1'b1;
         else if (vec_fetched_i) in_exc_q <= 1'b0;
      end
   end

   assign halted_o = halted_q;

   AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) halted_q |=> halted_q); // R10
   AST_DOUBLE_HALTS: assert property (@(posedge clk) disable iff (!rst_n) (fault_i && in_exc_q && !halted_q) |=> halted_q); // R7
   AST_RTE_HALTS: assert property (@(posedge clk) disable iff (!rst_n) (fault_i && rte_restore_i) |=> halted_q); // R8
endmodule

// File: rtl/fe_frame_regs.sv
module fe_frame_regs #(
   parameter int          VEC_W     = 8,
   parameter int          SR_W      = 16,
   parameter int          PC_W      = 32,
   parameter int          FMT_W     = 4,
   parameter int          SUP_BIT   = 13,
   parameter logic [15:0] TRACE_MASK = 16'hC000,
   parameter logic [3:0]  FMT_SHORT = 4'hA,
   parameter logic [3:0]  FMT_LONG  = 4'hB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept_i,
   input  logic [VEC_W-1:0]  vec_i,
   input  logic [VEC_W+1:0]  off_i,
   input  logic [FMT_W-1:0]  fmt_i,
   input  logic              long_i,
   input  logic [SR_W-1:0]   sr_i,
   input  logic [SR_W-1:0]   sr_new_i,
   input  logic [PC_W-1:0]   pc_i,
   output logic              take_o,
   output logic [VEC_W-1:0]  vec_o,
   output logic [VEC_W+1:0]  off_o,
   output logic [FMT_W-1:0]  fmt_o,
   output logic              long_o,
   output logic [SR_W-1:0]   sr_saved_o,
   output logic [SR_W-1:0]   sr_new_o,
   output logic [PC_W-1:0]   pc_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         take_o     <= 1'b0;
         vec_o      <= '0;
         off_o      <= '0;
         fmt_o      <= '0;
         long_o     <= 1'b0;
         sr_saved_o <= '0;
         sr_new_o   <= '0;
         pc_o       <= '0;
      end else begin
         take_o <= accept_i;
         if (accept_i) begin
            vec_o      <= vec_i;
            off_o      <= off_i;
            fmt_o      <= fmt_i;
            long_o     <= long_i;
            sr_saved_o <= sr_i;
            sr_new_o   <= sr_new_i;
            pc_o       <= pc_i;
         end
      end
   end

   AST_OFF_MATCH: assert property (@(posedge clk) disable iff (!rst_n) take_o |-> (off_o == {vec_o, 2'b00})); // R2
   AST_SR_SUPER: assert property (@(posedge clk) disable iff (!rst_n) take_o |-> (sr_new_o[SUP_BIT] && ((sr_new_o & SR_W'(TRACE_MASK)) == '0))); // R1
   AST_FMT_SIZE: assert property (@(posedge clk) disable iff (!rst_n) take_o |-> (fmt_o == (long_o ? FMT_W'(FMT_LONG) : FMT_W'(FMT_SHORT)))); // R5
   AST_TAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) take_o |=> !take_o); // R12
   AST_HOLD_VEC: assert property (@(posedge clk) disable iff (!rst_n) !take_o |-> $stable(vec_o)); // R12
endmodule

// File: rtl/fault_entry_seq.sv
module fault_entry_seq #(
   parameter int          VEC_W      = 8,
   parameter int          SR_W       = 16,
   parameter int          PC_W       = 32,
   parameter int          FMT_W      = 4,
   parameter int          SUP_BIT    = 13,
   parameter logic [15:0] TRACE_MASK = 16'hC000,
   parameter logic [3:0]  FMT_SHORT  = 4'hA,
   parameter logic [3:0]  FMT_LONG   = 4'hB,
   parameter int          VEC_BUS    = 2,
   parameter int          VEC_ADDR   = 3,
   parameter bit          BUS_WINS   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_err_i,
   input  logic             odd_fetch_i,
   input  logic             boundary_i,
   input  logic             rte_restore_i,
   input  logic             vec_fetched_i,
   input  logic [SR_W-1:0]  sr_i,
   input  logic [PC_W-1:0]  pc_i,
   output logic             fetch_inhibit_o,
   output logic             take_o,
   output logic [VEC_W-1:0] vec_num_o,
   output logic [VEC_W+1:0] vec_off_o,
   output logic [FMT_W-1:0] frame_fmt_o,
   output logic             long_frame_o,
   output logic [SR_W-1:0]  sr_saved_o,
   output logic [SR_W-1:0]  sr_new_o,
   output logic [PC_W-1:0]  pc_saved_o,
   output logic             halted_o,
   output logic             status_o,
   output logic             mem_wr_en_o
);
   logic             fault;
   logic             accept;
   logic [VEC_W-1:0] c_vec;
   logic [VEC_W+1:0] c_off;
   logic [FMT_W-1:0] c_fmt;
   logic             c_long;
   logic [SR_W-1:0]  c_sr_new;

   fe_classify #(
      .VEC_W(VEC_W), .SR_W(SR_W), .SUP_BIT(SUP_BIT), .TRACE_MASK(TRACE_MASK),
      .FMT_W(FMT_W), .FMT_SHORT(FMT_SHORT), .FMT_LONG(FMT_LONG),
      .VEC_BUS(VEC_BUS), .VEC_ADDR(VEC_ADDR), .BUS_WINS(BUS_WINS)
   ) u_classify (
      .bus_err_i(bus_err_i), .odd_fetch_i(odd_fetch_i), .boundary_i(boundary_i),
      .sr_i(sr_i), .fault_o(fault), .vec_o(c_vec), .off_o(c_off),
      .fmt_o(c_fmt), .long_o(c_long), .sr_new_o(c_sr_new)
   );

   fe_halt_track #(.RESET_IN_EXC(1'b1)) u_halt (
      .clk(clk), .rst_n(rst_n), .fault_i(fault), .rte_restore_i(rte_restore_i),
      .vec_fetched_i(vec_fetched_i), .accept_o(accept), .halted_o(halted_o)
   );

   fe_frame_regs #(
      .VEC_W(VEC_W), .SR_W(SR_W), .PC_W(PC_W), .FMT_W(FMT_W),
      .SUP_BIT(SUP_BIT), .TRACE_MASK(TRACE_MASK),
      .FMT_SHORT(FMT_SHORT), .FMT_LONG(FMT_LONG)
   ) u_frame (
      .clk(clk), .rst_n(rst_n), .accept_i(accept), .vec_i(c_vec), .off_i(c_off),
      .fmt_i(c_fmt), .long_i(c_long), .sr_i(sr_i), .sr_new_i(c_sr_new), .pc_i(pc_i),
      .take_o(take_o), .vec_o(vec_num_o), .off_o(vec_off_o), .fmt_o(frame_fmt_o),
      .long_o(long_frame_o), .sr_saved_o(sr_saved_o), .sr_new_o(sr_new_o), .pc_o(pc_saved_o)
   );

   assign fetch_inhibit_o = odd_fetch_i;
   assign status_o        = halted_o;
   assign mem_wr_en_o     = ~halted_o;

   AST_BUS_VECTOR: assert property (@(posedge clk) disable iff (!rst_n) (take_o && $past(bus_err_i) && BUS_WINS) |-> (vec_num_o == VEC_W'(VEC_BUS))); // R2
   AST_ADDR_VECTOR: assert property (@(posedge clk) disable iff (!rst_n) (take_o && $past(odd_fetch_i && !bus_err_i)) |-> (vec_num_o == VEC_W'(VEC_ADDR))); // R3
   AST_HALT_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n) halted_o |-> !take_o); // R10
endmodule

// File: tb/fault_entry_seq_tb.sv
`timescale 1ns/100ps
module fault_entry_seq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_err_i = 1'b0, odd_fetch_i = 1'b0, boundary_i = 1'b0;
   logic        rte_restore_i = 1'b0, vec_fetched_i = 1'b0;
   logic [15:0] sr_i = '0;
   logic [31:0] pc_i = '0;
   logic        fetch_inhibit_o, take_o, long_frame_o, halted_o, status_o, mem_wr_en_o;
   logic [7:0]  vec_num_o;
   logic [9:0]  vec_off_o;
   logic [3:0]  frame_fmt_o;
   logic [15:0] sr_saved_o, sr_new_o;
   logic [31:0] pc_saved_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   fault_entry_seq u_dut (
      .clk(clk), .rst_n(rst_n), .bus_err_i(bus_err_i), .odd_fetch_i(odd_fetch_i),
      .boundary_i(boundary_i), .rte_restore_i(rte_restore_i), .vec_fetched_i(vec_fetched_i),
      .sr_i(sr_i), .pc_i(pc_i), .fetch_inhibit_o(fetch_inhibit_o), .take_o(take_o),
      .vec_num_o(vec_num_o), .vec_off_o(vec_off_o), .frame_fmt_o(frame_fmt_o),
      .long_frame_o(long_frame_o), .sr_saved_o(sr_saved_o), .sr_new_o(sr_new_o),
      .pc_saved_o(pc_saved_o), .halted_o(halted_o), .status_o(status_o), .mem_wr_en_o(mem_wr_en_o)
   );

   typedef struct packed {
      logic        bus;
      logic        odd;
      logic        bnd;
      logic [15:0] sr;
      logic [31:0] pc;
      logic [7:0]  vec;
      logic        lng;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t TBL [NV] = '{
      '{1'b1, 1'b0, 1'b1, 16'h0000, 32'h0000_1000, 8'd2, 1'b0},  // R2 R5 short
      '{1'b1, 1'b0, 1'b0, 16'hC71F, 32'h0000_2004, 8'd2, 1'b1},  // R2 R5 long
      '{1'b0, 1'b1, 1'b1, 16'h8000, 32'h3000_0011, 8'd3, 1'b0},  // R3 short
      '{1'b0, 1'b1, 1'b0, 16'h4700, 32'h0040_0A01, 8'd3, 1'b1},  // R3 long
      '{1'b1, 1'b1, 1'b1, 16'hFFFF, 32'hDEAD_BEEF, 8'd2, 1'b0},  // R4
      '{1'b1, 1'b1, 1'b0, 16'h2000, 32'h1234_5678, 8'd2, 1'b1}   // R4
   };

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic clear_in();
      bus_err_i = 1'b0; odd_fetch_i = 1'b0; boundary_i = 1'b0;
      rte_restore_i = 1'b0; vec_fetched_i = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk); clear_in(); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic vfetch();
      @(negedge clk); clear_in(); vec_fetched_i = 1'b1;
      @(negedge clk); vec_fetched_i = 1'b0;
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

   initial begin
      do_reset();
      #1;
      chk("R10 reset halted", halted_o, 0);
      chk("R10 reset status", status_o, 0);
      chk("R10 reset wr_en", mem_wr_en_o, 1);
      chk("R12 reset take", take_o, 0);

      // R9: fault before vector fetch after reset is a double fault
      @(negedge clk); bus_err_i = 1'b1; boundary_i = 1'b1;
      @(posedge clk); #1;
      chk("R9 halt after reset fault", halted_o, 1);
      chk("R9 no take", take_o, 0);
      chk("R10 status high", status_o, 1);
      chk("R10 writes off", mem_wr_en_o, 0);
      @(negedge clk); clear_in(); vec_fetched_i = 1'b1;
      @(negedge clk); vec_fetched_i = 1'b0; odd_fetch_i = 1'b1;
      @(posedge clk); #1;
      chk("R10 fault ignored while halted", take_o, 0);
      chk("R10 halt held", halted_o, 1);
      do_reset(); #1;
      chk("R10 reset clears halt", halted_o, 0);

      // table walk: R1 R2 R3 R4 R5 R6 R11 R12
      for (int i = 0; i < NV; i++) begin
         vfetch();
         bus_err_i = TBL[i].bus; odd_fetch_i = TBL[i].odd; boundary_i = TBL[i].bnd;
         sr_i = TBL[i].sr; pc_i = TBL[i].pc;
         #1;
         chk("R3 fetch inhibit", fetch_inhibit_o, TBL[i].odd);
         @(posedge clk); #1;
         chk("R11 R12 take", take_o, 1);
         chk("R2 R3 R4 vector", vec_num_o, TBL[i].vec);
         chk("R2 offset", vec_off_o, {TBL[i].vec, 2'b00});
         chk("R5 long", long_frame_o, TBL[i].lng);
         chk("R5 format", frame_fmt_o, TBL[i].lng ? 4'hB : 4'hA);
         chk("R1 saved sr", sr_saved_o, TBL[i].sr);
         chk("R1 new sr", sr_new_o, (TBL[i].sr | 16'h2000) & 16'h3FFF);
         chk("R6 pc", pc_saved_o, TBL[i].pc);
         @(negedge clk); clear_in(); sr_i = 16'h1111; pc_i = 32'h0;
         @(posedge clk); #1;
         chk("R12 take pulse", take_o, 0);
         chk("R12 hold vector", vec_num_o, TBL[i].vec);
         chk("R12 hold pc", pc_saved_o, TBL[i].pc);
         chk("R11 no halt", halted_o, 0);
      end

      // R7: second fault before vector fetch
      @(negedge clk); bus_err_i = 1'b1; boundary_i = 1'b1;
      @(posedge clk); #1;
      chk("R7 double fault halts", halted_o, 1);
      chk("R7 no take", take_o, 0);
      chk("R7 vector unchanged", vec_num_o, 8'd2);

      // R8: fault during state restore
      do_reset();
      vfetch();
      rte_restore_i = 1'b1;
      @(posedge clk); #1;
      chk("R8 restore alone no halt", halted_o, 0);
      @(negedge clk); odd_fetch_i = 1'b1;
      @(posedge clk); #1;
      chk("R8 restore fault halts", halted_o, 1);
      chk("R8 no take", take_o, 0);
      @(negedge clk); clear_in();
      repeat (3) @(posedge clk); #1;
      chk("R10 halt sticky", status_o, 1);

      done = 1'b1;
      summary();
   end
endmodule